// File: doc/BRIEF.md
# Lane-Masked PHY Reset Sequencer

This block takes a serial PHY of up to 24 lanes through a per-lane reset. A start pulse captures a lane mask. Lane n takes part when mask bit (LANES-1-n) is set, so the most significant mask bit selects lane 0. The sequencer works in four phases:

- It turns off the run control of every selected lane.
- It waits until none of those lanes reports busy.
- It gives each selected lane an ordered receive, transmit and phase-rotator reset.
- It loads fixed receive tuning values and clears the lane power-down controls.

Every action leaves the block as a single register write toward a lane register file. Each write carries a lane index, a field code and a 4-bit value. The writes use a valid/ready handshake. A write counts as transferred on a clock edge where valid and ready are both high. The consumer may hold ready low for any number of cycles. While it does, the block keeps valid high and holds lane, field and data unchanged. No write is dropped or reordered. At most one write transfers per cycle.

The control and status pins (start, busy, done and I/O-valid) are plain levels. I/O-valid drops when a sequence is accepted and rises again when it completes.

Top module: `lane_rst_seq`

## Requirements
- R1: Lane n is selected when lane_mask_i bit (23-n) is set. No write ever names an unselected lane. The busy flag of an unselected lane (lane_busy_i bit n for lane n) has no effect.
- R2: The first writes of a sequence set field 0 (run control) to 0 on every selected lane, in ascending lane order.
- R3: After the stop writes, no further write is issued while any selected lane's busy flag is high. Progress resumes once all of them are low.
- R4: Each selected lane, in ascending order, receives six reset writes before the next lane starts. The writes are given as field=value:
  - field 1 (receive reset) = 1
  - field 2 (transmit reset) = 1
  - field 1 = 0
  - field 2 = 0
  - field 3 (phase-rotator reset) = 1
  - field 3 = 0
- R5: After all resets, each selected lane, in ascending order, receives ten tuning writes as field=value, in this order:
  - 4 (analog power-down) = 0
  - 5 (digital power-down) = 0
  - 7 (rotator resolution) = 7
  - 8 (phase step) = 12
  - 6 (transmit power-down) = 0
  - 9 (inertia) = 4
  - 10 (equaliser setting) = 3
  - 11 (gain bank A) = 11
  - 12 (gain bank B) = 11
  - 13 (gain bank E) = 11
- R6: While wr_valid_o is high and wr_ready_i is low, wr_valid_o stays high and lane, field and data are held stable. Back-pressure changes neither the content nor the order of the writes.
- R7: io_valid_o is 0 after reset. It goes low in the cycle after a start is accepted and stays low while busy. It goes high together with done_o.
- R8: After reset, busy_o, done_o and wr_valid_o are 0. busy_o is high from the cycle after an accepted start until completion. done_o then stays high until the next start.
- R9: A start pulse, and any mask change, that arrives while busy_o is high is ignored. The running sequence completes with its original lane set.
- R10: A start with an all-zero mask completes with no writes issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| lane_mask_i | input | 24 | Lane select, bit (23-n) selects lane n |
| lane_busy_i | input | 24 | Per-lane busy flag, bit n for lane n |
| wr_valid_o | output | 1 | Register write valid |
| wr_ready_i | input | 1 | Register write ready |
| wr_lane_o | output | 5 | Lane index of the write |
| wr_field_o | output | 4 | Field code of the write |
| wr_data_o | output | 4 | Value of the write |
| io_valid_o | output | 1 | Lane I/O valid indication |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed, held until next start |

## Verification
The bench reverses the lane mapping in its own model. A design that reads the mask in natural bit order writes to the wrong lanes, and the write log no longer matches. A busy flag is held on a selected lane while another flag is held on an unselected one. A design that ignores the busy gate issues reset writes too early, and one that honours unselected lanes never finishes. Random back-pressure catches designs that advance a step or a lane without a transfer. A second start sent during a run catches a design that restarts or relatches the mask. The empty mask catches a design that hangs or emits a stray write for lane 0.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int FIELD_W = 4;
  localparam int DATA_W  = 4;
  localparam int STEP_W  = 4;

  localparam int STOP_STEPS  = 1;
  localparam int RESET_STEPS = 6;
  localparam int TUNE_STEPS  = 10;

  typedef enum logic [FIELD_W-1:0] {
    F_RUN     = 4'd0,
    F_RX_RST  = 4'd1,
    F_TX_RST  = 4'd2,
    F_PR_RST  = 4'd3,
    F_ANA_PD  = 4'd4,
    F_DIG_PD  = 4'd5,
    F_TX_PD   = 4'd6,
    F_IQ_SEL  = 4'd7,
    F_PH_STEP = 4'd8,
    F_INERTIA = 4'd9,
    F_EQ_SET  = 4'd10,
    F_GAIN_A  = 4'd11,
    F_GAIN_B  = 4'd12,
    F_GAIN_E  = 4'd13
  } field_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_STOP,
    PH_WAIT,
    PH_RESET,
    PH_TUNE
  } phase_e;

  typedef struct packed {
    field_e              field;
    logic [DATA_W-1:0]   data;
  } wr_cmd_t;
endpackage

// File: rtl/lrs_lane_map.sv
module lrs_lane_map #(
  parameter int LANES = 24
) (
  input  logic [LANES-1:0] mask_i,
  output logic [LANES-1:0] en_o
);
  // lane n is selected by the mirrored mask bit
  for (genvar n = 0; n < LANES; n++) begin : g_rev
    assign en_o[n] = mask_i[LANES-1-n];
  end
endmodule

// File: rtl/lrs_lane_pick.sv
module lrs_lane_pick #(
  parameter int LANES  = 24,
  parameter int LANE_W = $clog2(LANES),
  parameter int PTR_W  = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]  en_i,
  input  logic [PTR_W-1:0]  from_i,
  output logic              found_o,
  output logic [LANE_W-1:0] idx_o
);
  // lowest selected lane at or above the pointer
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (en_i[i] && (PTR_W'(i) >= from_i)) begin
        found_o = 1'b1;
        idx_o   = LANE_W'(i);
      end
    end
  end
endmodule

// File: rtl/lrs_step_rom.sv
module lrs_step_rom
  import lrs_pkg::*;
(
  input  phase_e             phase_i,
  input  logic [STEP_W-1:0]  step_i,
  output wr_cmd_t            cmd_o,
  output logic               last_o
);
  always_comb begin
    cmd_o  = '{field: F_RUN, data: 4'd0};
    last_o = 1'b1;
    unique case (phase_i)
      PH_STOP: begin
        cmd_o  = '{field: F_RUN, data: 4'd0};
        last_o = (step_i == STEP_W'(STOP_STEPS - 1));
      end
      PH_RESET: begin
        last_o = (step_i == STEP_W'(RESET_STEPS - 1));
        case (step_i)
          4'd0:    cmd_o = '{field: F_RX_RST, data: 4'd1};
          4'd1:    cmd_o = '{field: F_TX_RST, data: 4'd1};
          4'd2:    cmd_o = '{field: F_RX_RST, data: 4'd0};
          4'd3:    cmd_o = '{field: F_TX_RST, data: 4'd0};
          4'd4:    cmd_o = '{field: F_PR_RST, data: 4'd1};
          default: cmd_o = '{field: F_PR_RST, data: 4'd0};
        endcase
      end
      PH_TUNE: begin
        last_o = (step_i == STEP_W'(TUNE_STEPS - 1));
        case (step_i)
          4'd0:    cmd_o = '{field: F_ANA_PD,  data: 4'd0};
          4'd1:    cmd_o = '{field: F_DIG_PD,  data: 4'd0};
          4'd2:    cmd_o = '{field: F_IQ_SEL,  data: 4'd7};
          4'd3:    cmd_o = '{field: F_PH_STEP, data: 4'd12};
          4'd4:    cmd_o = '{field: F_TX_PD,   data: 4'd0};
          4'd5:    cmd_o = '{field: F_INERTIA, data: 4'd4};
          4'd6:    cmd_o = '{field: F_EQ_SET,  data: 4'd3};
          4'd7:    cmd_o = '{field: F_GAIN_A,  data: 4'd11};
          4'd8:    cmd_o = '{field: F_GAIN_B,  data: 4'd11};
          default: cmd_o = '{field: F_GAIN_E,  data: 4'd11};
        endcase
      end
      default: begin
        cmd_o  = '{field: F_RUN, data: 4'd0};
        last_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/lrs_ctrl.sv
module lrs_ctrl
  import lrs_pkg::*;
#(
  parameter int LANES  = 24,
  parameter int LANE_W = $clog2(LANES),
  parameter int PTR_W  = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LANES-1:0]  mask_en_i,
  input  logic [LANES-1:0]  lane_busy_i,
  input  logic              pick_found_i,
  input  logic [LANE_W-1:0] pick_idx_i,
  input  logic              step_last_i,
  input  logic              wr_ready_i,
  output logic [LANES-1:0]  en_o,
  output logic [PTR_W-1:0]  ptr_o,
  output phase_e            phase_o,
  output logic [STEP_W-1:0] step_o,
  output logic              wr_valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              io_valid_o
);
  phase_e            phase_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [STEP_W-1:0] step_q;
  logic [LANES-1:0]  en_q;
  logic              done_q;
  logic              iov_q;
  logic              write_phase;
  logic              any_busy;

  assign write_phase = (phase_q == PH_STOP) || (phase_q == PH_RESET) || (phase_q == PH_TUNE);
  assign any_busy    = |(lane_busy_i & en_q);

  assign wr_valid_o = write_phase && pick_found_i;
  assign busy_o     = (phase_q != PH_IDLE);
  assign done_o     = done_q;
  assign io_valid_o = iov_q;
  assign en_o       = en_q;
  assign ptr_o      = ptr_q;
  assign phase_o    = phase_q;
  assign step_o     = step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ptr_q   <= '0;
      step_q  <= '0;
      en_q    <= '0;
      done_q  <= 1'b0;
      iov_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            en_q    <= mask_en_i;
            phase_q <= PH_STOP;
            ptr_q   <= '0;
            step_q  <= '0;
            done_q  <= 1'b0;
            iov_q   <= 1'b0;
          end
        end
        PH_WAIT: begin
          if (!any_busy) begin
            phase_q <= PH_RESET;
            ptr_q   <= '0;
            step_q  <= '0;
          end
        end
        default: begin
          if (!pick_found_i) begin
            ptr_q  <= '0;
            step_q <= '0;
            case (phase_q)
              PH_STOP:  phase_q <= PH_WAIT;
              PH_RESET: phase_q <= PH_TUNE;
              default: begin
                phase_q <= PH_IDLE;
                done_q  <= 1'b1;
                iov_q   <= 1'b1;
              end
            endcase
          end else if (wr_ready_i) begin
            if (step_last_i) begin
              step_q <= '0;
              ptr_q  <= PTR_W'(pick_idx_i) + PTR_W'(1);
            end else begin
              step_q <= step_q + STEP_W'(1);
            end
          end
        end
      endcase
    end
  end

  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(pick_idx_i) && $stable(step_q)); // R6
  AST_LANE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> en_q[pick_idx_i]); // R1
  AST_WAIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT) && any_busy |=> (phase_q == PH_WAIT) && !wr_valid_o); // R3
  AST_IOV_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !io_valid_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R8
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(en_q)); // R9
endmodule

// File: rtl/lane_rst_seq.sv
module lane_rst_seq
  import lrs_pkg::*;
#(
  parameter int LANES  = 24,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LANES-1:0]  lane_mask_i,
  input  logic [LANES-1:0]  lane_busy_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [LANE_W-1:0] wr_lane_o,
  output logic [FIELD_W-1:0] wr_field_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              io_valid_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int PTR_W = $clog2(LANES + 1);

  logic [LANES-1:0]  mask_en;
  logic [LANES-1:0]  en_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              pick_found;
  logic [LANE_W-1:0] pick_idx;
  phase_e            phase;
  logic [STEP_W-1:0] step;
  wr_cmd_t           cmd;
  logic              step_last;

  lrs_lane_map #(.LANES(LANES)) u_map (
    .mask_i (lane_mask_i),
    .en_o   (mask_en)
  );

  lrs_lane_pick #(.LANES(LANES), .LANE_W(LANE_W), .PTR_W(PTR_W)) u_pick (
    .en_i    (en_q),
    .from_i  (ptr_q),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  lrs_step_rom u_rom (
    .phase_i (phase),
    .step_i  (step),
    .cmd_o   (cmd),
    .last_o  (step_last)
  );

  lrs_ctrl #(.LANES(LANES), .LANE_W(LANE_W), .PTR_W(PTR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mask_en_i    (mask_en),
    .lane_busy_i  (lane_busy_i),
    .pick_found_i (pick_found),
    .pick_idx_i   (pick_idx),
    .step_last_i  (step_last),
    .wr_ready_i   (wr_ready_i),
    .en_o         (en_q),
    .ptr_o        (ptr_q),
    .phase_o      (phase),
    .step_o       (step),
    .wr_valid_o   (wr_valid_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .io_valid_o   (io_valid_o)
  );

  assign wr_lane_o  = pick_idx;
  assign wr_field_o = cmd.field;
  assign wr_data_o  = cmd.data;
endmodule

// File: tb/test_lane_rst_seq.sv
`timescale 1ns/1ps
module test_lane_rst_seq;
  localparam int LANES = 24;
  localparam int LOGN  = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] mask = '0;
  logic [23:0] lbusy = '0;
  logic        wr_valid, wr_ready;
  logic [4:0]  wr_lane;
  logic [3:0]  wr_field, wr_data;
  logic        io_valid, busy, done;

  always #2.5 clk = ~clk;

  lane_rst_seq i_lane_rst_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lane_mask_i(mask),
    .lane_busy_i(lbusy), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
    .wr_lane_o(wr_lane), .wr_field_o(wr_field), .wr_data_o(wr_data),
    .io_valid_o(io_valid), .busy_o(busy), .done_o(done)
  );

  int n_chk = 0;
  int n_err = 0;
  int log_n = 0;
  int exp_n = 0;
  logic [4:0] log_lane [LOGN];
  logic [3:0] log_f    [LOGN];
  logic [3:0] log_d    [LOGN];
  logic [4:0] exp_lane [LOGN];
  logic [3:0] exp_f    [LOGN];
  logic [3:0] exp_d    [LOGN];

  logic       bp_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always @(negedge clk) begin
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_ready <= bp_en ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) begin
    if (rst_n && wr_valid && wr_ready && log_n < LOGN) begin
      log_lane[log_n] = wr_lane;
      log_f[log_n]    = wr_field;
      log_d[log_n]    = wr_data;
      log_n++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add_exp(input int lane, input int f, input int d);
    exp_lane[exp_n] = 5'(lane);
    exp_f[exp_n]    = 4'(f);
    exp_d[exp_n]    = 4'(d);
    exp_n++;
  endtask

  task automatic build_exp(input logic [23:0] m);
    exp_n = 0;
    for (int n = 0; n < LANES; n++) if (m[23-n]) add_exp(n, 0, 0);
    for (int n = 0; n < LANES; n++) if (m[23-n]) begin
      add_exp(n, 1, 1); add_exp(n, 2, 1); add_exp(n, 1, 0);
      add_exp(n, 2, 0); add_exp(n, 3, 1); add_exp(n, 3, 0);
    end
    for (int n = 0; n < LANES; n++) if (m[23-n]) begin
      add_exp(n, 4, 0);  add_exp(n, 5, 0);  add_exp(n, 7, 7);
      add_exp(n, 8, 12); add_exp(n, 6, 0);  add_exp(n, 9, 4);
      add_exp(n, 10, 3); add_exp(n, 11, 11); add_exp(n, 12, 11);
      add_exp(n, 13, 11);
    end
  endtask

  task automatic compare_log(input string req);
    int bad = 0;
    chk(req, "write count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      if (log_lane[i] != exp_lane[i] || log_f[i] != exp_f[i] || log_d[i] != exp_d[i]) begin
        if (bad == 0)
          $display("  entry %0d: lane %0d field %0d data %0d, want lane %0d field %0d data %0d",
                   i, log_lane[i], log_f[i], log_d[i], exp_lane[i], exp_f[i], exp_d[i]);
        bad++;
      end
    end
    chk(req, "mismatched writes", bad, 0);
  endtask

  task automatic pulse_start(input logic [23:0] m);
    @(negedge clk);
    mask  = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!done && k < 5000) begin
      @(negedge clk);
      k++;
    end
    chk(req, "completion", int'(done), 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8", "busy after reset", int'(busy), 0);
    chk("R8", "done after reset", int'(done), 0);
    chk("R8", "valid after reset", int'(wr_valid), 0);
    chk("R7", "io_valid after reset", int'(io_valid), 0);
  endtask

  task automatic t_single_lane();
    log_n = 0;
    build_exp(24'h800000);
    pulse_start(24'h800000);
    chk("R8", "busy after start", int'(busy), 1);
    chk("R7", "io_valid after start", int'(io_valid), 0);
    wait_done("R8");
    compare_log("R2 R4 R5");
    chk("R7", "io_valid at done", int'(io_valid), 1);
    chk("R8", "busy at done", int'(busy), 0);
  endtask

  task automatic t_pattern_bp(input logic [23:0] m);
    bp_en = 1'b1;
    log_n = 0;
    build_exp(m);
    pulse_start(m);
    chk("R7", "io_valid drops on restart", int'(io_valid), 0);
    wait_done("R6");
    compare_log("R6 R1");
    bp_en = 1'b0;
  endtask

  task automatic t_busy_gate();
    logic [23:0] m = (24'd1 << 20) | (24'd1 << 13);
    log_n = 0;
    build_exp(m);
    lbusy = '0;
    lbusy[3] = 1'b1;
    lbusy[5] = 1'b1;
    pulse_start(m);
    repeat (40) @(negedge clk);
    chk("R3", "writes while lane busy", log_n, 2);
    chk("R3", "still busy", int'(busy), 1);
    chk("R7", "io_valid while waiting", int'(io_valid), 0);
    lbusy[3] = 1'b0;
    wait_done("R3");
    compare_log("R1 R3");
    lbusy = '0;
  endtask

  task automatic t_ignore_start();
    log_n = 0;
    build_exp(24'h000003);
    lbusy[22] = 1'b1;
    pulse_start(24'h000003);
    repeat (5) @(negedge clk);
    pulse_start(24'hFFFFFF);
    repeat (3) @(negedge clk);
    lbusy[22] = 1'b0;
    wait_done("R9");
    compare_log("R9");
    repeat (10) @(negedge clk);
    chk("R8", "done held", int'(done), 1);
  endtask

  task automatic t_empty();
    log_n = 0;
    pulse_start(24'h000000);
    wait_done("R10");
    chk("R10", "writes for empty mask", log_n, 0);
    chk("R7", "io_valid after empty run", int'(io_valid), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single_lane();
    t_pattern_bp(24'h5A0F31);
    t_pattern_bp(24'hFFFFFF);
    t_busy_gate();
    t_ignore_start();
    t_empty();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule